// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the control unit of a single-cycle, 32-bit load/store processor that supports 22 instructions. It reads the 6-bit primary opcode and the 6-bit function field of the current instruction and drives the datapath controls. These controls cover register write enable and destination, write-back source, ALU operand and operation, data memory strobes, branch kind and next-PC source. The block is purely combinational. The register file, the ALU and the memories sit outside it.

Decoding is done in two stages. Two 6-to-64 one-hot decoders first give one line per instruction. The function-field decoder is enabled only when the opcode is the register format (0). The instruction lines are then merged into three class terms: arithmetic, logic and immediate. Every control output is a short OR over instruction lines and class terms. A new instruction therefore needs one new line and a few extra OR inputs, and no other term in the decoder changes. Any opcode or function code outside the supported set leaves every control at zero. This means no register write, no memory access and sequential PC flow.

Top module: `instr_ctrl_dec`

## Requirements
- R1: Exactly these 22 encodings are recognised, with register-format instructions at opcode 0 selected by function code. The function codes are add 32, sub 34, slt 42, and 36, or 37, xor 38, nor 39, jr 8 and syscall 12. The remaining instructions are selected by opcode alone: bltz 1, j 2, jal 3, beq 4, bne 5, addi 8, slti 10, andi 12, ori 13, xori 14, lui 15, lw 35 and sw 43.
- R2: `rf_wr_en` is 1 for lui, lw, jal and for every arithmetic (add, sub, slt, addi, slti) and logic (and, or, xor, nor, andi, ori, xori) instruction, and 0 for all other codes.
- R3: `rf_dst_sel` is 01 (rd) for the seven register-format ALU instructions and 10 (register 31) for jal. It is 00 (rt) for every other code.
- R4: `wb_src_sel` is 01 (ALU result) for lui and the arithmetic and logic classes, and 10 (incremented PC) for jal. It is 00 (data memory) for every other code.
- R5: `alu_b_imm` is 1 (sign-extended immediate) for lui, addi, slti, andi, ori, xori, lw and sw, and 0 (register rt) otherwise.
- R6: `alu_kind` is 10 (add/subtract) for add, sub, addi, lw and sw. It is 01 (set-less-than) for slt and slti, 11 (bitwise) for the logic class, and 00 (upper-immediate pass) for lui and every non-ALU code. `alu_sub` is 1 exactly for sub, slt and slti.
- R7: `logic_fn` is 00 for and/andi, 01 for or/ori, 10 for xor/xori, 11 for nor, and 00 for every non-logic code.
- R8: `dmem_rd` is 1 only for lw, and `dmem_wr` is 1 only for sw.
- R9: `br_kind` is 01 for beq, 10 for bne, 11 for bltz, and 00 otherwise.
- R10: `pc_src` is 01 (jump target) for j and jal, 10 (register) for jr, 11 (fixed system-call address) for syscall, and 00 (incremented or branch PC) otherwise.
- R11: The function field has no effect when the opcode is not 0. Every output for such an opcode is the same for any function code.
- R12: An unrecognised opcode, or opcode 0 with an unrecognised function code, drives every output to 0, so that both write enables are low and PC flow is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, used only for opcode 0 |
| rf_wr_en | output | 1 | Register file write enable |
| rf_dst_sel | output | 2 | Destination register: 00 rt, 01 rd, 10 register 31 |
| wb_src_sel | output | 2 | Write-back data: 00 memory, 01 ALU, 10 incremented PC |
| alu_b_imm | output | 1 | ALU second operand: 0 rt, 1 sign-extended immediate |
| alu_kind | output | 2 | ALU function class: 00 upper-imm, 01 slt, 10 add/sub, 11 logic |
| alu_sub | output | 1 | Adder subtracts when 1 |
| logic_fn | output | 2 | Bitwise op: 00 and, 01 or, 10 xor, 11 nor |
| dmem_rd | output | 1 | Data memory read enable |
| dmem_wr | output | 1 | Data memory write enable |
| br_kind | output | 2 | Branch: 00 none, 01 equal, 10 not equal, 11 less than zero |
| pc_src | output | 2 | Next PC: 00 sequential/branch, 01 jump, 10 register, 11 syscall |

## Verification
Every output of this block is a function of the current opcode and function field and carries no register. Each result is therefore due in the same cycle as its stimulus, after the combinational logic settles. The bench drives a new instruction on the falling clock edge and samples one time unit later, well before the next rising edge. The checker's immediate assertions evaluate the settled outputs on every change of the inputs.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  typedef enum int {
    I_ADD, I_SUB, I_SLT, I_AND, I_OR, I_XOR, I_NOR, I_JR, I_SYSCALL,
    I_LUI, I_ADDI, I_SLTI, I_ANDI, I_ORI, I_XORI,
    I_LW, I_SW, I_J, I_JAL, I_BEQ, I_BNE, I_BLTZ, I_COUNT
  } ins_e;

  localparam int NUM_INS = int'(I_COUNT);
  localparam logic [OPC_W-1:0] OP_RFMT = '0;

  // output encodings
  localparam logic [1:0] DST_RT = 2'b00, DST_RD = 2'b01, DST_R31 = 2'b10;
  localparam logic [1:0] WB_MEM = 2'b00, WB_ALU = 2'b01, WB_PC = 2'b10;

  // instructions below this index are selected by the function field
  function automatic bit ins_uses_fn(int i);
    return i <= int'(I_SYSCALL);
  endfunction

  function automatic int ins_code(int i);
    case (i)
      int'(I_ADD):     return 32;
      int'(I_SUB):     return 34;
      int'(I_SLT):     return 42;
      int'(I_AND):     return 36;
      int'(I_OR):      return 37;
      int'(I_XOR):     return 38;
      int'(I_NOR):     return 39;
      int'(I_JR):      return 8;
      int'(I_SYSCALL): return 12;
      int'(I_LUI):     return 15;
      int'(I_ADDI):    return 8;
      int'(I_SLTI):    return 10;
      int'(I_ANDI):    return 12;
      int'(I_ORI):     return 13;
      int'(I_XORI):    return 14;
      int'(I_LW):      return 35;
      int'(I_SW):      return 43;
      int'(I_J):       return 2;
      int'(I_JAL):     return 3;
      int'(I_BEQ):     return 4;
      int'(I_BNE):     return 5;
      default:         return 1; // bltz
    endcase
  endfunction
endpackage

// File: rtl/ctl_onehot_dec.sv
module ctl_onehot_dec #(
  parameter int IN_W = 6,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic             en,
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] hot
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot[i] = en && (code == IN_W'(i));
  end
endmodule

// File: rtl/ctl_instr_sel.sv
module ctl_instr_sel
  import ctl_dec_pkg::*;
#(
  parameter int OPC_N = 1 << OPC_W,
  parameter int FN_N  = 1 << FN_W
) (
  input  logic [OPC_N-1:0]   op_hot,
  input  logic [FN_N-1:0]    fn_hot,
  output logic [NUM_INS-1:0] ins
);
  for (genvar i = 0; i < NUM_INS; i++) begin : g_ins
    if (ins_uses_fn(i)) begin : g_fn
      assign ins[i] = fn_hot[ins_code(i)];
    end else begin : g_op
      assign ins[i] = op_hot[ins_code(i)];
    end
  end

  // lines of the 64-way decoders that carry no supported instruction
  logic unused_lines;
  assign unused_lines = ^{op_hot, fn_hot};
endmodule

// File: rtl/ctl_class_enc.sv
module ctl_class_enc
  import ctl_dec_pkg::*;
(
  input  logic [NUM_INS-1:0] ins,
  output logic               rf_wr_en,
  output logic [1:0]         rf_dst_sel,
  output logic [1:0]         wb_src_sel,
  output logic               alu_b_imm,
  output logic [1:0]         alu_kind,
  output logic               alu_sub,
  output logic [1:0]         logic_fn,
  output logic               dmem_rd,
  output logic               dmem_wr,
  output logic [1:0]         br_kind,
  output logic [1:0]         pc_src
);
  logic arith_c, logic_c, imm_c, rfmt_alu;

  // first level: class terms
  assign arith_c  = ins[I_ADD] | ins[I_SUB] | ins[I_SLT] | ins[I_ADDI] | ins[I_SLTI];
  assign logic_c  = ins[I_AND] | ins[I_OR] | ins[I_XOR] | ins[I_NOR]
                  | ins[I_ANDI] | ins[I_ORI] | ins[I_XORI];
  assign imm_c    = ins[I_LUI] | ins[I_ADDI] | ins[I_SLTI]
                  | ins[I_ANDI] | ins[I_ORI] | ins[I_XORI];
  assign rfmt_alu = ins[I_ADD] | ins[I_SUB] | ins[I_SLT] | ins[I_AND]
                  | ins[I_OR] | ins[I_XOR] | ins[I_NOR];

  // second level: datapath controls
  assign rf_wr_en      = ins[I_LUI] | arith_c | logic_c | ins[I_LW] | ins[I_JAL];
  assign rf_dst_sel[0] = rfmt_alu;
  assign rf_dst_sel[1] = ins[I_JAL];
  assign wb_src_sel[0] = ins[I_LUI] | arith_c | logic_c;
  assign wb_src_sel[1] = ins[I_JAL];
  assign alu_b_imm     = imm_c | ins[I_LW] | ins[I_SW];

  assign alu_kind[1]   = ins[I_ADD] | ins[I_SUB] | ins[I_ADDI] | ins[I_LW] | ins[I_SW] | logic_c;
  assign alu_kind[0]   = ins[I_SLT] | ins[I_SLTI] | logic_c;
  assign alu_sub       = ins[I_SUB] | ins[I_SLT] | ins[I_SLTI];
  assign logic_fn[0]   = ins[I_OR] | ins[I_ORI] | ins[I_NOR];
  assign logic_fn[1]   = ins[I_XOR] | ins[I_XORI] | ins[I_NOR];

  assign dmem_rd       = ins[I_LW];
  assign dmem_wr       = ins[I_SW];
  assign br_kind[0]    = ins[I_BEQ] | ins[I_BLTZ];
  assign br_kind[1]    = ins[I_BNE] | ins[I_BLTZ];
  assign pc_src[0]     = ins[I_J] | ins[I_JAL] | ins[I_SYSCALL];
  assign pc_src[1]     = ins[I_JR] | ins[I_SYSCALL];
endmodule

// File: rtl/instr_ctrl_dec.sv
module instr_ctrl_dec
  import ctl_dec_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       rf_wr_en,
  output logic [1:0] rf_dst_sel,
  output logic [1:0] wb_src_sel,
  output logic       alu_b_imm,
  output logic [1:0] alu_kind,
  output logic       alu_sub,
  output logic [1:0] logic_fn,
  output logic       dmem_rd,
  output logic       dmem_wr,
  output logic [1:0] br_kind,
  output logic [1:0] pc_src
);
  localparam int OPC_N = 1 << OPC_W;
  localparam int FN_N  = 1 << FN_W;

  logic [OPC_N-1:0]   op_hot;
  logic [FN_N-1:0]    fn_hot;
  logic [NUM_INS-1:0] ins;

  ctl_onehot_dec #(.IN_W(OPC_W)) u_op_dec (
    .en(1'b1), .code(opcode), .hot(op_hot)
  );

  // function decoder qualified by the register-format opcode line
  ctl_onehot_dec #(.IN_W(FN_W)) u_fn_dec (
    .en(op_hot[OP_RFMT]), .code(funct), .hot(fn_hot)
  );

  ctl_instr_sel #(.OPC_N(OPC_N), .FN_N(FN_N)) u_sel (
    .op_hot(op_hot), .fn_hot(fn_hot), .ins(ins)
  );

  ctl_class_enc u_enc (
    .ins(ins),
    .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel), .wb_src_sel(wb_src_sel),
    .alu_b_imm(alu_b_imm), .alu_kind(alu_kind), .alu_sub(alu_sub),
    .logic_fn(logic_fn), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .br_kind(br_kind), .pc_src(pc_src)
  );
endmodule

// File: rtl/ctl_dec_chk.sv
module ctl_dec_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       rf_wr_en,
  input logic [1:0] rf_dst_sel,
  input logic [1:0] wb_src_sel,
  input logic       alu_b_imm,
  input logic [1:0] alu_kind,
  input logic       alu_sub,
  input logic [1:0] logic_fn,
  input logic       dmem_rd,
  input logic       dmem_wr,
  input logic [1:0] br_kind,
  input logic [1:0] pc_src
);
  logic op_known, fn_known;
  always_comb begin
    op_known = opcode inside {6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd10,
                              6'd12, 6'd13, 6'd14, 6'd15, 6'd35, 6'd43};
    fn_known = funct inside {6'd8, 6'd12, 6'd32, 6'd34, 6'd36, 6'd37,
                             6'd38, 6'd39, 6'd42};
  end

  always_comb begin
    // R8
    mem_excl_chk: assert (!(dmem_rd && dmem_wr));
    // R2
    store_no_wr_chk: assert (!dmem_wr || !rf_wr_en);
    // R4
    load_wb_chk: assert (!dmem_rd || (rf_wr_en && wb_src_sel == 2'b00));
    // R3
    link_dst_chk: assert (rf_dst_sel != 2'b10 || (rf_wr_en && wb_src_sel == 2'b10 && pc_src == 2'b01));
    // R10
    flow_excl_chk: assert (pc_src == 2'b00 || br_kind == 2'b00);
    // R12
    illegal_op_chk: assert (op_known || (!rf_wr_en && !dmem_wr && !dmem_rd && pc_src == 2'b00 && br_kind == 2'b00));
    // R12
    illegal_fn_chk: assert (opcode != 6'd0 || fn_known || (!rf_wr_en && pc_src == 2'b00));
    // R7
    logic_fn_idle_chk: assert (alu_kind == 2'b11 || logic_fn == 2'b00);
    // R5
    imm_src_chk: assert (!alu_b_imm || rf_dst_sel == 2'b00);
  end
endmodule

bind instr_ctrl_dec ctl_dec_chk u_chk (
  .opcode(opcode), .funct(funct), .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel),
  .wb_src_sel(wb_src_sel), .alu_b_imm(alu_b_imm), .alu_kind(alu_kind),
  .alu_sub(alu_sub), .logic_fn(logic_fn), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
  .br_kind(br_kind), .pc_src(pc_src)
);

// File: tb/tb_instr_ctrl_dec.sv
`timescale 1ns/1ps
module tb_instr_ctrl_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] opcode, funct;
  logic rf_wr_en, alu_b_imm, alu_sub, dmem_rd, dmem_wr;
  logic [1:0] rf_dst_sel, wb_src_sel, alu_kind, logic_fn, br_kind, pc_src;

  instr_ctrl_dec dut (
    .opcode(opcode), .funct(funct), .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel),
    .wb_src_sel(wb_src_sel), .alu_b_imm(alu_b_imm), .alu_kind(alu_kind),
    .alu_sub(alu_sub), .logic_fn(logic_fn), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .br_kind(br_kind), .pc_src(pc_src)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {opcode, funct, we, dst, wb, imm, kind, sub, lfn, mrd, mwr, br, pc}
  localparam int NV = 22;
  localparam logic [28:0] VEC [NV] = '{
    {6'd0,  6'd32, 17'b1_01_01_0_10_0_00_0_0_00_00}, // add
    {6'd0,  6'd34, 17'b1_01_01_0_10_1_00_0_0_00_00}, // sub
    {6'd0,  6'd42, 17'b1_01_01_0_01_1_00_0_0_00_00}, // slt
    {6'd0,  6'd36, 17'b1_01_01_0_11_0_00_0_0_00_00}, // and
    {6'd0,  6'd37, 17'b1_01_01_0_11_0_01_0_0_00_00}, // or
    {6'd0,  6'd38, 17'b1_01_01_0_11_0_10_0_0_00_00}, // xor
    {6'd0,  6'd39, 17'b1_01_01_0_11_0_11_0_0_00_00}, // nor
    {6'd0,  6'd8,  17'b0_00_00_0_00_0_00_0_0_00_10}, // jr
    {6'd0,  6'd12, 17'b0_00_00_0_00_0_00_0_0_00_11}, // syscall
    {6'd15, 6'd0,  17'b1_00_01_1_00_0_00_0_0_00_00}, // lui
    {6'd8,  6'd0,  17'b1_00_01_1_10_0_00_0_0_00_00}, // addi
    {6'd10, 6'd0,  17'b1_00_01_1_01_1_00_0_0_00_00}, // slti
    {6'd12, 6'd0,  17'b1_00_01_1_11_0_00_0_0_00_00}, // andi
    {6'd13, 6'd0,  17'b1_00_01_1_11_0_01_0_0_00_00}, // ori
    {6'd14, 6'd0,  17'b1_00_01_1_11_0_10_0_0_00_00}, // xori
    {6'd35, 6'd0,  17'b1_00_00_1_10_0_00_1_0_00_00}, // lw
    {6'd43, 6'd0,  17'b0_00_00_1_10_0_00_0_1_00_00}, // sw
    {6'd2,  6'd0,  17'b0_00_00_0_00_0_00_0_0_00_01}, // j
    {6'd3,  6'd0,  17'b1_10_10_0_00_0_00_0_0_00_01}, // jal
    {6'd4,  6'd0,  17'b0_00_00_0_00_0_00_0_0_01_00}, // beq
    {6'd5,  6'd0,  17'b0_00_00_0_00_0_00_0_0_10_00}, // bne
    {6'd1,  6'd0,  17'b0_00_00_0_00_0_00_0_0_11_00}  // bltz
  };

  function automatic logic [16:0] outs();
    return {rf_wr_en, rf_dst_sel, wb_src_sel, alu_b_imm, alu_kind, alu_sub,
            logic_fn, dmem_rd, dmem_wr, br_kind, pc_src};
  endfunction

  task automatic chk(string req, string what, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [5:0] op, logic [5:0] fn);
    @(negedge clk);
    opcode = op;
    funct  = fn;
    #1;
  endtask

  // per-field comparison, each field tagged with its requirement
  task automatic check_fields(string tag, logic [16:0] e);
    logic [16:0] g;
    g = outs();
    chk("R2",  {tag, " rf_wr_en"},   17'(g[16]),    17'(e[16]));
    chk("R3",  {tag, " rf_dst_sel"}, 17'(g[15:14]), 17'(e[15:14]));
    chk("R4",  {tag, " wb_src_sel"}, 17'(g[13:12]), 17'(e[13:12]));
    chk("R5",  {tag, " alu_b_imm"},  17'(g[11]),    17'(e[11]));
    chk("R6",  {tag, " alu_kind"},   17'(g[10:9]),  17'(e[10:9]));
    chk("R6",  {tag, " alu_sub"},    17'(g[8]),     17'(e[8]));
    chk("R7",  {tag, " logic_fn"},   17'(g[7:6]),   17'(e[7:6]));
    chk("R8",  {tag, " dmem"},       17'(g[5:4]),   17'(e[5:4]));
    chk("R9",  {tag, " br_kind"},    17'(g[3:2]),   17'(e[3:2]));
    chk("R10", {tag, " pc_src"},     17'(g[1:0]),   17'(e[1:0]));
  endtask

  initial begin
    opcode = '0;
    funct  = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero word is not a supported instruction (R12)
    apply(6'd0, 6'd0);
    chk("R12", "reset-state zero word", outs(), '0);

    // R1: every supported encoding, full word and per field
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28:23], VEC[i][22:17]);
      chk("R1", $sformatf("vector %0d word", i), outs(), VEC[i][16:0]);
      check_fields($sformatf("vector %0d", i), VEC[i][16:0]);
    end

    // R11: function field ignored for non-zero opcodes
    for (int i = 9; i < NV; i++) begin
      for (int f = 1; f < 64; f += 13) begin
        apply(VEC[i][28:23], 6'(f));
        chk("R11", $sformatf("vector %0d funct %0d", i, f), outs(), VEC[i][16:0]);
      end
    end
    apply(6'd35, 6'd63);
    chk("R11", "lw with funct 63", outs(), VEC[15][16:0]);

    // R12: illegal function codes under opcode 0
    apply(6'd0, 6'd1);
    chk("R12", "op0 funct 1", outs(), '0);
    apply(6'd0, 6'd33);
    chk("R12", "op0 funct 33", outs(), '0);
    apply(6'd0, 6'd63);
    chk("R12", "op0 funct 63", outs(), '0);

    // R12: unsupported opcodes, any funct
    for (int op = 0; op < 64; op++) begin
      if (!(op inside {0, 1, 2, 3, 4, 5, 8, 10, 12, 13, 14, 15, 35, 43})) begin
        apply(6'(op), 6'd32);
        chk("R12", $sformatf("opcode %0d", op), outs(), '0);
      end
    end

    // R8 boundary: store then load back to back keep strobes separate
    apply(6'd43, 6'd0);
    chk("R8", "sw strobes", 17'({dmem_rd, dmem_wr}), 17'b01);
    apply(6'd35, 6'd0);
    chk("R8", "lw strobes", 17'({dmem_rd, dmem_wr}), 17'b10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule